// File: doc/BRIEF.md
# Adapter Option-Select Register File

This block sits on an expansion adapter and lets system software identify the card and hand it resources without jumpers. Each slot has an active-low setup select. While that select is low, a window of eight byte-wide I/O registers at 0100h to 0107h accepts reads and writes. The two lowest registers return a fixed 16-bit card identifier. The others hold the writable configuration: an enable bit, a 16-bit I/O base, an interrupt level and a DMA arbitration level.

The configuration fields come out as plain outputs. A small port decoder inside the block uses them to claim ordinary I/O cycles that fall in the adapter's own 8-port block. That decoder stays silent while the card is disabled and while the slot is in setup. Software reads the identifier, writes the fields and then deasserts the select. The card then answers at its assigned base.

Top module: `optsel_regfile`

## Requirements
- R1: A read is answered only when `setup_sel_n` is 0, `bus_rd` is 1 and `bus_addr` lies in 0100h..0107h. In that case `rd_drive` is 1 and `bus_rdata` carries the register selected by `bus_addr[2:0]`. In every other case `rd_drive` is 0 and `bus_rdata` is 00h.
- R2: Register 0 reads as the low byte of parameter `CARD_ID` and register 1 as its high byte. With the default `CARD_ID` of 5A3Ch these are 3Ch and 5Ah.
- R3: Writes to registers 0, 1 and 7 have no effect. Registers 0 and 1 keep returning the identifier, and register 7 always reads 00h.
- R4: Bit 0 of register 2 is the card enable and drives `card_enable`. Bits 7:1 of register 2 read as 0.
- R5: Register 3 holds bits 7:0 of `io_base` and register 4 holds bits 15:8.
- R6: Bits 3:0 of register 5 give `irq_level` and bits 3:0 of register 6 give `arb_level`. Bits 7:4 of both registers read as 0.
- R7: While reset is asserted, registers 2 to 6 and all configuration outputs are 0, so the card starts disabled.
- R8: With `setup_sel_n` at 1, accesses to the window do not change any register and do not produce read data.
- R9: `io_hit` is 1 when `card_enable` is 1, `setup_sel_n` is 1, `bus_rd` or `bus_wr` is 1, and `bus_addr[15:3]` equals `io_base[15:3]`.
- R10: `io_hit` is 0 while `card_enable` is 0 or while `setup_sel_n` is 0, whatever the address.
- R11: A configuration write takes effect at the next rising clock edge. A read of the same register in the same cycle returns the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| setup_sel_n | input | 1 | Active-low setup select for this slot |
| bus_addr | input | 16 | I/O address |
| bus_rd | input | 1 | I/O read strobe |
| bus_wr | input | 1 | I/O write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte; 00h when not driving |
| rd_drive | output | 1 | High while the block answers a configuration read |
| card_enable | output | 1 | Adapter enable from register 2 bit 0 |
| io_base | output | 16 | Assigned I/O base address |
| irq_level | output | 4 | Assigned interrupt level |
| arb_level | output | 4 | Assigned DMA arbitration level |
| io_hit | output | 1 | Normal I/O cycle falls in the adapter's 8-port block |

## Verification
The read path and the write path can act on the same register in the same cycle. The bench raises `bus_rd` and `bus_wr` together on the interrupt-level register. Before the clock edge it expects the old value on `bus_rdata`. After the edge it expects the new value on both `bus_rdata` and `irq_level`. A second interaction, between a configuration change and the normal-cycle decoder, is judged by clearing the enable and showing that `io_hit` drops for the same address on the following cycle.

// File: rtl/optsel_pkg.sv
`timescale 1ns/1ps
package optsel_pkg;

  localparam int unsigned NREG  = 8;
  localparam int unsigned IDX_W = $clog2(NREG);

  typedef logic [7:0] byte_t;

  typedef enum logic [IDX_W-1:0] {
    RIX_ID_LO   = 3'd0,
    RIX_ID_HI   = 3'd1,
    RIX_CTRL    = 3'd2,
    RIX_BASE_LO = 3'd3,
    RIX_BASE_HI = 3'd4,
    RIX_IRQ     = 3'd5,
    RIX_ARB     = 3'd6,
    RIX_RSVD    = 3'd7
  } reg_idx_e;

  // Writable bits of each slot; zero means the slot holds no storage.
  function automatic byte_t field_mask(int idx, int irq_w, int arb_w, int iob_w);
    byte_t m;
    case (idx)
      2:       m = 8'h01;
      3:       m = 8'hFF;
      4:       m = byte_t'((1 << (iob_w - 8)) - 1);
      5:       m = byte_t'((1 << irq_w) - 1);
      6:       m = byte_t'((1 << arb_w) - 1);
      default: m = 8'h00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/optsel_rst_sync.sv
`timescale 1ns/1ps
module optsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/optsel_win_dec.sv
`timescale 1ns/1ps
module optsel_win_dec
  import optsel_pkg::*;
#(
  parameter int unsigned    ADDR_W   = 16,
  parameter logic [15:0]    WIN_BASE = 16'h0100
) (
  input  logic              setup_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              rd_drive,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [NREG-1:0]   wr_en
);

  logic in_window;
  logic cfg_active;

  always_comb begin
    in_window  = (bus_addr[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
    cfg_active = !setup_sel_n && in_window;
    reg_idx    = bus_addr[IDX_W-1:0];
    rd_drive   = cfg_active && bus_rd;
    wr_en      = (cfg_active && bus_wr) ? (NREG'(1) << reg_idx) : '0;
  end

endmodule

// File: rtl/optsel_cfg_regs.sv
`timescale 1ns/1ps
module optsel_cfg_regs
  import optsel_pkg::*;
#(
  parameter logic [15:0] CARD_ID = 16'h5A3C,
  parameter int unsigned IRQ_W   = 4,
  parameter int unsigned ARB_W   = 4,
  parameter int unsigned IOB_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       wr_en,
  input  byte_t                 wdata,
  output logic [NREG-1:0][7:0]  regs
);

  // Slots 0, 1 and 7 take no writes.
  logic unused_wr;
  assign unused_wr = &{wr_en[RIX_ID_LO], wr_en[RIX_ID_HI], wr_en[RIX_RSVD]};

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam byte_t MASK = field_mask(g, IRQ_W, ARB_W, IOB_W);
    if (g == RIX_ID_LO) begin : g_id_lo
      assign regs[g] = CARD_ID[7:0];
    end else if (g == RIX_ID_HI) begin : g_id_hi
      assign regs[g] = CARD_ID[15:8];
    end else if (MASK == 8'h00) begin : g_empty
      assign regs[g] = '0;
    end else begin : g_store
      byte_t slot_q;
      byte_t slot_d;

      always_comb begin
        slot_d = wdata & MASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= '0;
        end else if (wr_en[g]) begin
          slot_q <= slot_d;
        end
      end

      assign regs[g] = slot_q;
    end
  end

  // R4: a write to the control slot lands its bit 0 at the next edge.
  assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[RIX_CTRL] |=> (regs[RIX_CTRL] == {7'b0, $past(wdata[0])}));

  // R8: without a write strobe no slot moves.
  assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(regs));

endmodule

// File: rtl/optsel_io_decode.sv
`timescale 1ns/1ps
module optsel_io_decode #(
  parameter int unsigned HI_W = 13
) (
  input  logic            setup_sel_n,
  input  logic            card_enable,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] base_hi,
  output logic            io_hit
);

  logic cycle_live;
  logic block_match;

  always_comb begin
    cycle_live  = bus_rd || bus_wr;
    block_match = (addr_hi == base_hi);
    io_hit      = setup_sel_n && card_enable && cycle_live && block_match;
  end

endmodule

// File: rtl/optsel_regfile.sv
`timescale 1ns/1ps
module optsel_regfile
  import optsel_pkg::*;
#(
  parameter logic [15:0] CARD_ID     = 16'h5A3C,
  parameter logic [15:0] WIN_BASE    = 16'h0100,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IRQ_W       = 4,
  parameter int unsigned ARB_W       = 4,
  parameter int unsigned SPAN_LOG2   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rd_drive,
  output logic              card_enable,
  output logic [ADDR_W-1:0] io_base,
  output logic [IRQ_W-1:0]  irq_level,
  output logic [ARB_W-1:0]  arb_level,
  output logic              io_hit
);

  localparam int unsigned HI_W = ADDR_W - SPAN_LOG2;

  logic                 rst_n_s;
  logic [IDX_W-1:0]     reg_idx;
  logic [NREG-1:0]      wr_en;
  logic [NREG-1:0][7:0] regs;

  optsel_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  optsel_win_dec #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
    .setup_sel_n (setup_sel_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .rd_drive    (rd_drive),
    .reg_idx     (reg_idx),
    .wr_en       (wr_en)
  );

  optsel_cfg_regs #(
    .CARD_ID (CARD_ID),
    .IRQ_W   (IRQ_W),
    .ARB_W   (ARB_W),
    .IOB_W   (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (wr_en),
    .wdata (bus_wdata),
    .regs  (regs)
  );

  always_comb begin
    card_enable = regs[RIX_CTRL][0];
    io_base     = {regs[RIX_BASE_HI][ADDR_W-9:0], regs[RIX_BASE_LO]};
    irq_level   = regs[RIX_IRQ][IRQ_W-1:0];
    arb_level   = regs[RIX_ARB][ARB_W-1:0];
    bus_rdata   = rd_drive ? regs[reg_idx] : 8'h00;
  end

  optsel_io_decode #(.HI_W(HI_W)) u_dec (
    .setup_sel_n (setup_sel_n),
    .card_enable (card_enable),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .addr_hi     (bus_addr[ADDR_W-1:SPAN_LOG2]),
    .base_hi     (io_base[ADDR_W-1:SPAN_LOG2]),
    .io_hit      (io_hit)
  );

  // R1: data is driven only for a selected read.
  assert_drive_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_drive |-> (!setup_sel_n && bus_rd));

  // R2: slot 0 always returns the identifier low byte.
  assert_id_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_drive && bus_addr[IDX_W-1:0] == RIX_ID_LO) |-> (bus_rdata == CARD_ID[7:0]));

  // R8: the assigned base cannot move while the slot is out of setup.
  assert_base_kept_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    setup_sel_n |=> $stable(io_base));

  // R10: the port decoder never claims a cycle during setup or while disabled.
  assert_no_hit_when_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    io_hit |-> (setup_sel_n && card_enable));

endmodule

// File: tb/optsel_regfile_test.sv
`timescale 1ns/1ps
module optsel_regfile_test;

  logic        clk;
  logic        rst_n;
  logic        setup_sel_n;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        rd_drive;
  logic        card_enable;
  logic [15:0] io_base;
  logic [3:0]  irq_level;
  logic [3:0]  arb_level;
  logic        io_hit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  optsel_regfile uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_sel_n (setup_sel_n),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .rd_drive    (rd_drive),
    .card_enable (card_enable),
    .io_base     (io_base),
    .irq_level   (irq_level),
    .arb_level   (arb_level),
    .io_hit      (io_hit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    setup_sel_n = 1'b1;
    bus_rd      = 1'b0;
    bus_wr      = 1'b0;
    bus_addr    = 16'h0000;
    bus_wdata   = 8'h00;
  endtask

  task automatic cfg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    setup_sel_n = 1'b0;
    bus_addr    = a;
    bus_wdata   = d;
    bus_wr      = 1'b1;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic cfg_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    setup_sel_n = 1'b0;
    bus_addr    = a;
    bus_rd      = 1'b1;
    #1;
    check(req, $sformatf("rdata @%h", a), bus_rdata, exp);
    check(req, $sformatf("rd_drive @%h", a), rd_drive, 1'b1);
    idle_bus();
  endtask

  task automatic normal_cycle(input string req, input logic [15:0] a,
                              input logic sel_n, input logic rd, input logic exp_hit);
    @(negedge clk);
    setup_sel_n = sel_n;
    bus_addr    = a;
    bus_rd      = rd;
    #1;
    check(req, $sformatf("io_hit @%h", a), io_hit, exp_hit);
    idle_bus();
  endtask

  // R7: cleared after reset
  task automatic t_reset_state();
    check("R7", "card_enable", card_enable, 1'b0);
    check("R7", "io_base", io_base, 16'h0000);
    check("R7", "irq_level", irq_level, 4'h0);
    check("R7", "arb_level", arb_level, 4'h0);
    for (int i = 2; i < 7; i++) cfg_read("R7", 16'h0100 + 16'(i), 8'h00);
  endtask

  // R2: identifier bytes
  task automatic t_ident();
    cfg_read("R2", 16'h0100, 8'h3C);
    cfg_read("R2", 16'h0101, 8'h5A);
  endtask

  // R3: fixed slots ignore writes
  task automatic t_fixed_slots();
    cfg_write(16'h0100, 8'hFF);
    cfg_write(16'h0101, 8'h00);
    cfg_write(16'h0107, 8'hA5);
    cfg_read("R3", 16'h0100, 8'h3C);
    cfg_read("R3", 16'h0101, 8'h5A);
    cfg_read("R3", 16'h0107, 8'h00);
  endtask

  // R4 R5 R6: writable fields
  task automatic t_fields();
    cfg_write(16'h0102, 8'hFF);
    cfg_read("R4", 16'h0102, 8'h01);
    check("R4", "card_enable", card_enable, 1'b1);
    cfg_write(16'h0103, 8'h40);
    cfg_write(16'h0104, 8'h03);
    check("R5", "io_base", io_base, 16'h0340);
    cfg_read("R5", 16'h0103, 8'h40);
    cfg_read("R5", 16'h0104, 8'h03);
    cfg_write(16'h0105, 8'hF7);
    cfg_write(16'h0106, 8'hAB);
    cfg_read("R6", 16'h0105, 8'h07);
    cfg_read("R6", 16'h0106, 8'h0B);
    check("R6", "irq_level", irq_level, 4'h7);
    check("R6", "arb_level", arb_level, 4'hB);
  endtask

  // R1 R8: deselected or out-of-window accesses
  task automatic t_deselected();
    @(negedge clk);
    setup_sel_n = 1'b1;
    bus_addr    = 16'h0100;
    bus_rd      = 1'b1;
    #1;
    check("R8", "rd_drive deselected", rd_drive, 1'b0);
    check("R8", "rdata deselected", bus_rdata, 8'h00);
    idle_bus();
    @(negedge clk);
    setup_sel_n = 1'b1;
    bus_addr    = 16'h0103;
    bus_wdata   = 8'h99;
    bus_wr      = 1'b1;
    @(negedge clk);
    idle_bus();
    check("R8", "io_base after deselected write", io_base, 16'h0340);
    cfg_read("R8", 16'h0103, 8'h40);
    @(negedge clk);
    setup_sel_n = 1'b0;
    bus_addr    = 16'h0108;
    bus_rd      = 1'b1;
    #1;
    check("R1", "rd_drive outside window", rd_drive, 1'b0);
    check("R1", "rdata outside window", bus_rdata, 8'h00);
    idle_bus();
  endtask

  // R9 R10: normal-cycle decode
  task automatic t_decode();
    normal_cycle("R9", 16'h0345, 1'b1, 1'b1, 1'b1);
    normal_cycle("R9", 16'h0340, 1'b1, 1'b1, 1'b1);
    normal_cycle("R9", 16'h0348, 1'b1, 1'b1, 1'b0);
    normal_cycle("R9", 16'h033F, 1'b1, 1'b1, 1'b0);
    normal_cycle("R9", 16'h0345, 1'b1, 1'b0, 1'b0);
    normal_cycle("R10", 16'h0345, 1'b0, 1'b1, 1'b0);
    cfg_write(16'h0102, 8'h00);
    normal_cycle("R10", 16'h0345, 1'b1, 1'b1, 1'b0);
    cfg_write(16'h0102, 8'h01);
    normal_cycle("R9", 16'h0347, 1'b1, 1'b1, 1'b1);
  endtask

  // R11: read and write of the same slot in one cycle
  task automatic t_same_cycle();
    @(negedge clk);
    setup_sel_n = 1'b0;
    bus_addr    = 16'h0105;
    bus_wdata   = 8'h03;
    bus_rd      = 1'b1;
    bus_wr      = 1'b1;
    #1;
    check("R11", "rdata before edge", bus_rdata, 8'h07);
    check("R11", "irq_level before edge", irq_level, 4'h7);
    @(posedge clk);
    #1;
    check("R11", "rdata after edge", bus_rdata, 8'h03);
    check("R11", "irq_level after edge", irq_level, 4'h3);
    @(negedge clk);
    idle_bus();
  endtask

  // R7: reset in the middle of operation
  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", "card_enable in reset", card_enable, 1'b0);
    check("R7", "io_base in reset", io_base, 16'h0000);
    check("R7", "irq_level in reset", irq_level, 4'h0);
    check("R7", "arb_level in reset", arb_level, 4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg_read("R7", 16'h0102, 8'h00);
    cfg_read("R7", 16'h0104, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_ident();
    t_fixed_slots();
    t_fields();
    t_deselected();
    t_decode();
    t_same_cycle();
    t_mid_reset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule